// File: doc/BRIEF.md
# CAN Error Counter and Bus-Off Supervisor

This block keeps the two fault counters of a CAN node, one for the transmit side and one for the receive side. It turns their values into a warning flag and a bus-off flag. The protocol engine reports error events, each with a 3-bit error type and the side it happened on. It also reports extra increments during a long disturbance and a pulse for each message transferred without error. The block weights each event and moves the matching counter. It also latches the type of the most recent error into a last-error-code field.

When either counter reaches its limit, the node goes bus-off: the counters freeze, bus activity stops and the initialisation hold bit is forced on. Recovery starts only after software clears that bit. From then on, every pulse from the recessive-bit sampler marks a run of 11 recessive bits and writes the Bit0 code into the last-error-code field. After the configured number of runs, both counters return to zero and both flags drop. Each flag change produces a one-cycle event for the error interrupt logic.

Top module: `can_fault_supervisor`

## Requirements
- R1: After reset, `tec`, `rec` and `lec` are 0, `warn`, `bus_off`, `warn_chg` and `boff_chg` are 0, and `init` is 1.
- R2: An error event with a valid type adds 8 to `tec` when `err_on_tx` is 1, or 1 to `rec` when `err_on_tx` is 0, in the cycle after the event.
- R3: An `err_burst` pulse adds one further increment of the same weight to the side chosen by `err_on_tx` and leaves `lec` unchanged. It adds to an error event in the same cycle.
- R4: `tx_done` lowers `tec` by 1 and `rx_done` lowers `rec` by 1, in the same cycle as any increments. A counter never goes below 0 and saturates at 255.
- R5: An error event with type 0 or 7 is ignored: neither counter nor `lec` changes.
- R6: `lec` holds the type of the last accepted error event. The codes are 1 stuff, 2 form, 3 acknowledge, 4 Bit1, 5 Bit0 and 6 CRC; 0 means no error, and 7 never appears.
- R7: `warn` is 1 while either counter is 96 or more. It clears once both counters are below 96, and it stays 1 throughout bus-off.
- R8: When a counter reaches 255, `bus_off` and `init` go to 1 in the same cycle. While `bus_off` is 1, error, burst and transfer pulses change neither counter nor `lec`.
- R9: A `recessive_11` pulse is ignored unless `bus_off` is 1 and `init` is 0. While `init` is 1, runs neither count toward recovery nor change `lec`.
- R10: Each counted recovery run writes code 5 (Bit0) into `lec`.
- R11: On the 128th counted run, `tec` and `rec` become 0 and `bus_off` and `warn` become 0.
- R12: `warn_chg` and `boff_chg` pulse for exactly one cycle, in the cycle in which `warn` or `bus_off` takes its new value, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 1 | Error event pulse from the protocol engine |
| err_code | input | 3 | Error type for the event |
| err_on_tx | input | 1 | Side of the event or burst: 1 transmit, 0 receive |
| err_burst | input | 1 | One more run of 8 erroneous bits during a long disturbance |
| tx_done | input | 1 | Successful transmission pulse |
| rx_done | input | 1 | Successful reception pulse |
| recessive_11 | input | 1 | Sampler pulse: 11 consecutive recessive bits seen |
| init_wr | input | 1 | Software write strobe for the initialisation hold bit |
| init_wdata | input | 1 | Value written to the hold bit |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter |
| warn | output | 1 | Error warning flag |
| bus_off | output | 1 | Bus-off flag; bus activity must stop while it is set |
| init | output | 1 | Initialisation hold bit |
| warn_chg | output | 1 | One-cycle pulse on any change of `warn` |
| boff_chg | output | 1 | One-cycle pulse on any change of `bus_off` |
| lec | output | 3 | Last error code |

## Verification
The assertions check four things on every cycle: counters stay frozen through bus-off, bus-off entry forces `init`, a falling bus-off leaves both counters at zero with both change pulses, and the change pulses agree with the flag history. The bench scenarios cover what needs a sequence of events: the weights and the floor at zero, the exact threshold crossings at 96 and 255, the ignored error types, and the recovery count. That count must reach exactly 128, with runs seen while the hold bit is set left out.

// File: rtl/can_fault_supervisor.sv
module can_fault_supervisor #(
  parameter int CW           = 8,
  parameter int TX_STEP      = 8,
  parameter int RX_STEP      = 1,
  parameter int WARN_AT      = 96,
  parameter int OFF_AT       = 255,
  parameter int RECOVER_RUNS = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_valid,
  input  logic [2:0]    err_code,
  input  logic          err_on_tx,
  input  logic          err_burst,
  input  logic          tx_done,
  input  logic          rx_done,
  input  logic          recessive_11,
  input  logic          init_wr,
  input  logic          init_wdata,
  output logic [CW-1:0] tec,
  output logic [CW-1:0] rec,
  output logic          warn,
  output logic          bus_off,
  output logic          init,
  output logic          warn_chg,
  output logic          boff_chg,
  output logic [2:0]    lec
);

  localparam int RW = (RECOVER_RUNS > 1) ? $clog2(RECOVER_RUNS) : 1;
  localparam logic [RW-1:0] LAST_RUN = RW'(RECOVER_RUNS - 1);
  localparam logic [2:0] CODE_BIT0 = 3'd5;

  logic [RW-1:0] runs;
  logic [CW-1:0] tec_n, rec_n;
  logic          hit, enter, run_ok, done, warn_n, boff_n;
  int            tx_add, rx_add;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c, input int add, input logic dec);
    int v;
    v = int'(c) + add - (dec ? 1 : 0);
    if (v < 0) v = 0;
    if (v > OFF_AT) v = OFF_AT;
    return CW'(v);
  endfunction

  assign hit    = err_valid && err_code != 3'd0 && err_code != 3'd7;
  assign tx_add = ((hit && err_on_tx) ? TX_STEP : 0) + ((err_burst && err_on_tx) ? TX_STEP : 0);
  assign rx_add = ((hit && !err_on_tx) ? RX_STEP : 0) + ((err_burst && !err_on_tx) ? RX_STEP : 0);
  assign tec_n  = bus_off ? tec : step(tec, tx_add, tx_done);
  assign rec_n  = bus_off ? rec : step(rec, rx_add, rx_done);
  assign enter  = !bus_off && (int'(tec_n) >= OFF_AT || int'(rec_n) >= OFF_AT);
  assign run_ok = bus_off && !init && recessive_11;
  assign done   = run_ok && runs == LAST_RUN;
  assign warn_n = !done && (int'(tec_n) >= WARN_AT || int'(rec_n) >= WARN_AT);
  assign boff_n = enter || (bus_off && !done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec      <= '0;
      rec      <= '0;
      warn     <= 1'b0;
      bus_off  <= 1'b0;
      init     <= 1'b1;
      warn_chg <= 1'b0;
      boff_chg <= 1'b0;
      lec      <= 3'd0;
      runs     <= '0;
    end else begin
      tec      <= done ? '0 : tec_n;
      rec      <= done ? '0 : rec_n;
      warn     <= warn_n;
      bus_off  <= boff_n;
      warn_chg <= warn_n != warn;
      boff_chg <= boff_n != bus_off;
      if (enter)        init <= 1'b1;
      else if (init_wr) init <= init_wdata;
      if (!bus_off && hit) lec <= err_code;
      else if (run_ok)     lec <= CODE_BIT0;
      if (enter || done) runs <= '0;
      else if (run_ok)   runs <= runs + 1'b1;
    end
  end

  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_off) && bus_off) |-> ($stable(tec) && $stable(rec)));

  p_entry_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_off) |-> init);

  p_recovered_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_off) |-> (tec == '0 && rec == '0 && !warn && warn_chg && boff_chg));

  p_warn_in_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |-> warn);

  p_warn_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    warn_chg == (warn != $past(warn)));

  p_boff_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    boff_chg == (bus_off != $past(bus_off)));

  p_lec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lec != 3'd7);

endmodule

// File: tb/can_fault_supervisor_test.sv
`timescale 1ns/1ps
module can_fault_supervisor_test;
  logic clk = 0, rst_n = 0;
  logic err_valid = 0, err_on_tx = 0, err_burst = 0, tx_done = 0, rx_done = 0;
  logic recessive_11 = 0, init_wr = 0, init_wdata = 0;
  logic [2:0] err_code = 0;
  logic [7:0] tec, rec;
  logic warn, bus_off, init, warn_chg, boff_chg;
  logic [2:0] lec;
  int checks = 0, fails = 0;
  bit  ended = 0;

  always #5 clk = ~clk;

  can_fault_supervisor uut (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_code(err_code),
    .err_on_tx(err_on_tx), .err_burst(err_burst), .tx_done(tx_done), .rx_done(rx_done),
    .recessive_11(recessive_11), .init_wr(init_wr), .init_wdata(init_wdata),
    .tec(tec), .rec(rec), .warn(warn), .bus_off(bus_off), .init(init),
    .warn_chg(warn_chg), .boff_chg(boff_chg), .lec(lec));

  // row: ev, code, tx, burst, oktx, okrx | tec, rec, warn, lec
  // Rows cover R2 R3 R4 R5 R6 R7.
  localparam int NV = 26;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1,3'd4,1'b1,1'b0,1'b0,1'b0, 8'd8,  8'd0,1'b0,3'd4},
    {1'b1,3'd2,1'b0,1'b0,1'b0,1'b0, 8'd8,  8'd1,1'b0,3'd2},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 8'd7,  8'd1,1'b0,3'd2},
    {1'b0,3'd0,1'b0,1'b0,1'b0,1'b1, 8'd7,  8'd0,1'b0,3'd2},
    {1'b0,3'd0,1'b0,1'b0,1'b0,1'b1, 8'd7,  8'd0,1'b0,3'd2},
    {1'b1,3'd0,1'b1,1'b0,1'b0,1'b0, 8'd7,  8'd0,1'b0,3'd2},
    {1'b1,3'd7,1'b0,1'b0,1'b0,1'b0, 8'd7,  8'd0,1'b0,3'd2},
    {1'b1,3'd1,1'b1,1'b1,1'b0,1'b0, 8'd23, 8'd0,1'b0,3'd1},
    {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 8'd31, 8'd0,1'b0,3'd1},
    {1'b1,3'd3,1'b0,1'b0,1'b0,1'b1, 8'd31, 8'd0,1'b0,3'd3},
    {1'b1,3'd6,1'b1,1'b0,1'b1,1'b0, 8'd38, 8'd0,1'b0,3'd6},
    {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 8'd46, 8'd0,1'b0,3'd6},
    {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 8'd54, 8'd0,1'b0,3'd6},
    {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 8'd62, 8'd0,1'b0,3'd6},
    {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 8'd70, 8'd0,1'b0,3'd6},
    {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 8'd78, 8'd0,1'b0,3'd6},
    {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 8'd86, 8'd0,1'b0,3'd6},
    {1'b0,3'd0,1'b1,1'b1,1'b0,1'b0, 8'd94, 8'd0,1'b0,3'd6},
    {1'b1,3'd5,1'b1,1'b0,1'b0,1'b0, 8'd102,8'd0,1'b1,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 8'd101,8'd0,1'b1,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 8'd100,8'd0,1'b1,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 8'd99, 8'd0,1'b1,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 8'd98, 8'd0,1'b1,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 8'd97, 8'd0,1'b1,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 8'd96, 8'd0,1'b1,3'd5},
    {1'b0,3'd0,1'b0,1'b0,1'b1,1'b0, 8'd95, 8'd0,1'b0,3'd5}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic ev, input logic [2:0] code, input logic tx, input logic bu,
                     input logic ot, input logic orx, input logic rr);
    err_valid = ev; err_code = code; err_on_tx = tx; err_burst = bu;
    tx_done = ot; rx_done = orx; recessive_11 = rr;
    @(posedge clk); #1;
    err_valid = 0; err_code = 0; err_on_tx = 0; err_burst = 0;
    tx_done = 0; rx_done = 0; recessive_11 = 0;
  endtask

  task automatic set_init(input logic v);
    init_wr = 1; init_wdata = v;
    @(posedge clk); #1;
    init_wr = 0;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 tec", tec, 0); chk("R1 rec", rec, 0); chk("R1 lec", lec, 0);
    chk("R1 warn", warn, 0); chk("R1 bus_off", bus_off, 0); chk("R1 init", init, 1);
    chk("R1 chg", {warn_chg, boff_chg}, 0);
    rst_n = 1;
    @(posedge clk); #1;
    set_init(0);
    chk("R1 init write", init, 0);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      cyc(v[27], v[26:24], v[23], v[22], v[21], v[20], 1'b0);
      chk($sformatf("R2/R3/R4/R5 tec row%0d", i), tec, v[19:12]);
      chk($sformatf("R2/R4 rec row%0d", i), rec, v[11:4]);
      chk($sformatf("R7 warn row%0d", i), warn, v[3]);
      chk($sformatf("R6 lec row%0d", i), lec, v[2:0]);
    end

    // R12 warning change pulse
    cyc(1, 3'd4, 1, 0, 0, 0, 0);
    chk("R7 warn set", warn, 1); chk("R12 warn_chg pulse", warn_chg, 1);
    chk("R12 boff_chg quiet", boff_chg, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R12 warn_chg one cycle", warn_chg, 0);

    // R9 runs outside bus-off ignored
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R9 run ignored lec", lec, 4);

    // R8 transmit side bus-off: 103 + 18*8 = 247, one more reaches 255
    for (int i = 0; i < 18; i++) cyc(0, 0, 1, 1, 0, 0, 0);
    chk("R8 tec before limit", tec, 247); chk("R8 not off yet", bus_off, 0);
    cyc(0, 0, 1, 1, 0, 0, 0);
    chk("R8 tec at limit", tec, 255); chk("R8 bus_off", bus_off, 1);
    chk("R8 init forced", init, 1); chk("R12 boff_chg", boff_chg, 1);
    chk("R12 warn_chg quiet", warn_chg, 0);
    cyc(1, 3'd2, 1, 0, 0, 0, 0);
    chk("R8 error ignored tec", tec, 255); chk("R8 error ignored lec", lec, 4);
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R8 transfer ignored", tec, 255);
    cyc(1, 3'd2, 0, 1, 0, 1, 0);
    chk("R8 rx side frozen", rec, 0);

    // R9 runs with init held
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R9 held lec", lec, 4); chk("R9 still off", bus_off, 1);
    set_init(0);
    chk("R9 init cleared", init, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R10 lec bit0", lec, 5);
    for (int i = 0; i < 126; i++) cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R11 off after 127", bus_off, 1); chk("R11 tec held", tec, 255);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R11 bus_off clear", bus_off, 0); chk("R11 tec zero", tec, 0);
    chk("R11 rec zero", rec, 0); chk("R11 warn clear", warn, 0);
    chk("R12 both chg", {warn_chg, boff_chg}, 3);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R12 chg ends", {warn_chg, boff_chg}, 0);

    // receive side thresholds
    for (int i = 0; i < 95; i++) cyc(1, 3'd1, 0, 0, 0, 0, 0);
    chk("R2 rec 95", rec, 95); chk("R7 rec below", warn, 0);
    cyc(1, 3'd1, 0, 0, 0, 0, 0);
    chk("R7 rec at 96", warn, 1);
    for (int i = 0; i < 158; i++) cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R3 rec burst 254", rec, 254); chk("R8 rx not off", bus_off, 0);
    cyc(0, 0, 0, 1, 0, 0, 0);
    chk("R8 rx bus_off", bus_off, 1); chk("R8 rx init", init, 1);
    chk("R3 burst lec kept", lec, 1);

    rst_n = 0;
    @(posedge clk); #1;
    chk("R1 reset off", bus_off, 0); chk("R1 reset rec", rec, 0);
    chk("R1 reset lec", lec, 0);
    finish_run();
  end
endmodule